// File: doc/BRIEF.md
# Control-Mode Sequence Hunter

This block watches the received character stream of a synchronous, byte-oriented data link while the station is idle. It looks for the short sequences that start an exchange. A line bid is a bare ENQ. A poll or select is a station address made of printable characters followed by ENQ. The block takes bytes from a receiver that has already found character alignment, with one valid strobe per byte. It forwards every accepted address character and the ENQ on a capture port, and it raises a done strobe with the address length once the ENQ is confirmed by a following pad byte. When a sequence turns out to be malformed, it pulses a flush strobe so that the consumer can drop what it has collected. The hunt then starts again.

A text block that begins on the line while the station is idle may belong to another station, and transparent data inside it can look like a poll. To keep such data from being taken as a poll, the block hands control to a downstream block framer as soon as text starts. It holds a monitor request until the framer reports the end of that block, and then it resumes the hunt from scratch. A synchronous abort lets the protocol layer cancel the hunt at any time, for example before it sends a line bid of its own.

Top module: `ctl_seq_hunter`

## Requirements
- R1: After reset, `cap_valid_o`, `cap_flush_o`, `done_o` and `mon_req_o` are low, and `lgr_count_o` is zero.
- R2: A byte in the range 0x40 to 0xFE received while hunting is an address character. It appears on `cap_byte_o` with `cap_valid_o` high in the cycle after it is accepted. Captured bytes keep their arrival order.
- R3: A SYN byte (0x32) received while hunting is dropped. It is never captured and it does not change the address count.
- R4: An ENQ (0x2D) after zero address characters, or after 2 to 15 of them, is captured. If the next valid byte has its low four bits all ones, `done_o` pulses for one cycle in the following cycle, with `lgr_count_o` equal to the number of address characters.
- R5: If the byte after a captured ENQ does not have its low four bits all ones, `cap_flush_o` pulses instead of `done_o` and the hunt restarts.
- R6: An ENQ that follows exactly one address character is not captured. `cap_flush_o` pulses and the hunt restarts with a count of zero.
- R7: A sixteenth consecutive address character is not captured. `cap_flush_o` pulses and counting restarts from zero, so at most 15 address characters are captured between flushes.
- R8: Any other control byte (0x00 to 0x3F or 0xFF, apart from SYN, ENQ, SOH, STX and DLE) restarts the hunt. `cap_flush_o` pulses only if something had been captured.
- R9: SOH (0x01), STX (0x02), or DLE (0x10) followed by STX sets `mon_req_o` from the next cycle onwards. Any collected characters are flushed. While `mon_req_o` is high, received bytes are ignored. `mon_req_o` falls in the cycle after `mon_end_i` is sampled high, and the hunt then starts afresh.
- R10: A DLE followed by any byte other than STX restarts the hunt. That second byte is neither captured nor counted, and collected characters are flushed.
- R11: When `abort_i` is sampled high, the block is back in the hunt state in the next cycle. In that cycle `mon_req_o` is low, `lgr_count_o` is zero, and any collected characters are flushed. The byte presented in the abort cycle is ignored.
- R12: `lgr_count_o` keeps the count reported with the last `done_o` until the next `done_o` or abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous cancel of the current hunt |
| rx_byte_i | input | 8 | Received character |
| rx_valid_i | input | 1 | Qualifies `rx_byte_i` for one cycle |
| mon_end_i | input | 1 | Framer reports that the monitored text block has ended |
| cap_byte_o | output | 8 | Captured address character or ENQ |
| cap_valid_o | output | 1 | Qualifies `cap_byte_o` |
| cap_flush_o | output | 1 | Discard all bytes captured since the last done or flush |
| done_o | output | 1 | One-cycle strobe: a valid sequence was recognised |
| lgr_count_o | output | 4 | Number of address characters in the last recognised sequence |
| mon_req_o | output | 1 | Text block in progress; the framer owns the stream |

## Verification
A wrong internal state usually shows up one cycle after the byte that exposes it. A lost or extra address count shows as the wrong `lgr_count_o` on the done strobe. A missed reject shows as a capture of a byte that should have been dropped, or as a done with no flush before it. A stuck monitor state keeps `mon_req_o` high and silences the capture port after `mon_end_i`. The scoreboard therefore compares every capture, flush and done in strict order, so that one misplaced event is caught at the exact cycle where it appears.

// File: rtl/ctl_hunt_pkg.sv
package ctl_hunt_pkg;

  // Character codes of the received line code
  localparam logic [7:0] CH_SYN = 8'h32;
  localparam logic [7:0] CH_ENQ = 8'h2D;
  localparam logic [7:0] CH_DLE = 8'h10;
  localparam logic [7:0] CH_STX = 8'h02;
  localparam logic [7:0] CH_SOH = 8'h01;

  // Printable (address) character range
  localparam logic [7:0] GR_LO = 8'h40;
  localparam logic [7:0] GR_HI = 8'hFE;

  typedef enum logic [2:0] {
    CLS_SYN,
    CLS_ENQ,
    CLS_DLE,
    CLS_STX,
    CLS_SOH,
    CLS_GRAPHIC,
    CLS_CTRL
  } byte_cls_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_DLE,
    ST_PAD,
    ST_MON
  } hunt_st_t;

  function automatic logic is_graphic(input logic [7:0] b);
    return (b >= GR_LO) && (b <= GR_HI);
  endfunction

  function automatic logic pad_good(input logic [7:0] b);
    return &b[3:0];
  endfunction

  function automatic byte_cls_t classify(input logic [7:0] b);
    byte_cls_t c;
    if (b == CH_SYN)       c = CLS_SYN;
    else if (b == CH_ENQ)  c = CLS_ENQ;
    else if (b == CH_DLE)  c = CLS_DLE;
    else if (b == CH_STX)  c = CLS_STX;
    else if (b == CH_SOH)  c = CLS_SOH;
    else if (is_graphic(b)) c = CLS_GRAPHIC;
    else                   c = CLS_CTRL;
    return c;
  endfunction

endpackage

// File: rtl/ctl_hunt_classify.sv
module ctl_hunt_classify
  import ctl_hunt_pkg::*;
(
  input  logic [7:0] rx_byte,
  output byte_cls_t  cls,
  output logic       pad_ok
);

  always_comb begin
    cls    = classify(rx_byte);
    pad_ok = pad_good(rx_byte);
  end

endmodule

// File: rtl/ctl_hunt_lgr_cnt.sv
module ctl_hunt_lgr_cnt #(
  parameter int MAX_LGR = 15,
  parameter int MIN_LGR = 2,
  parameter int CNT_W   = $clog2(MAX_LGR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max,
  output logic             too_few,
  output logic             held
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LGR);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LGR);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign at_max  = (cnt_q == MAX_C);
  assign held    = (cnt_q != '0);
  assign too_few = held && (cnt_q < MIN_C);

endmodule

// File: rtl/ctl_hunt_fsm.sv
module ctl_hunt_fsm
  import ctl_hunt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort_i,
  input  logic      rx_valid,
  input  byte_cls_t cls,
  input  logic      pad_ok,
  input  logic      at_max,
  input  logic      too_few,
  input  logic      cnt_held,
  input  logic      mon_end_i,
  output hunt_st_t  state,
  output logic      ev_store,
  output logic      ev_restart,
  output logic      ev_flush,
  output logic      ev_done,
  output logic      ev_mon_enter,
  output logic      cnt_clr,
  output logic      cnt_inc
);

  hunt_st_t st_q, st_d;
  logic     held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HUNT;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d         = st_q;
    ev_store     = 1'b0;
    ev_restart   = 1'b0;
    ev_done      = 1'b0;
    ev_mon_enter = 1'b0;
    cnt_inc      = 1'b0;
    if (abort_i) begin
      st_d       = ST_HUNT;
      ev_restart = 1'b1;
    end else begin
      unique case (st_q)
        ST_HUNT: if (rx_valid) begin
          unique case (cls)
            CLS_SYN: ;
            CLS_GRAPHIC: begin
              if (at_max) ev_restart = 1'b1;
              else begin
                ev_store = 1'b1;
                cnt_inc  = 1'b1;
              end
            end
            CLS_ENQ: begin
              if (too_few) ev_restart = 1'b1;
              else begin
                ev_store = 1'b1;
                st_d     = ST_PAD;
              end
            end
            CLS_DLE: st_d = ST_DLE;
            CLS_STX, CLS_SOH: begin
              ev_mon_enter = 1'b1;
              st_d         = ST_MON;
            end
            default: ev_restart = 1'b1;
          endcase
        end
        ST_DLE: if (rx_valid) begin
          if (cls == CLS_STX) begin
            ev_mon_enter = 1'b1;
            st_d         = ST_MON;
          end else begin
            ev_restart = 1'b1;
            st_d       = ST_HUNT;
          end
        end
        ST_PAD: if (rx_valid) begin
          st_d = ST_HUNT;
          if (pad_ok) ev_done    = 1'b1;
          else        ev_restart = 1'b1;
        end
        ST_MON: if (mon_end_i) st_d = ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  // Something is collected downstream when address bytes were counted or an ENQ waits for its pad
  assign held     = cnt_held || (st_q == ST_PAD);
  assign ev_flush = (ev_restart || ev_mon_enter) && held;
  assign cnt_clr  = ev_restart || ev_mon_enter || ev_done;
  assign state    = st_q;

endmodule

// File: rtl/ctl_seq_hunter.sv
module ctl_seq_hunter
  import ctl_hunt_pkg::*;
#(
  parameter int MAX_LGR = 15,
  parameter int MIN_LGR = 2,
  parameter int CNT_W   = $clog2(MAX_LGR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_valid_i,
  input  logic             mon_end_i,
  output logic [7:0]       cap_byte_o,
  output logic             cap_valid_o,
  output logic             cap_flush_o,
  output logic             done_o,
  output logic [CNT_W-1:0] lgr_count_o,
  output logic             mon_req_o
);

  byte_cls_t        cls;
  logic             pad_ok;
  logic [CNT_W-1:0] cnt;
  logic             at_max, too_few, cnt_held;
  logic             cnt_clr, cnt_inc;
  hunt_st_t         state;
  logic             ev_store, ev_restart, ev_flush, ev_done, ev_mon_enter;

  ctl_hunt_classify u_cls (
    .rx_byte (rx_byte_i),
    .cls     (cls),
    .pad_ok  (pad_ok)
  );

  ctl_hunt_lgr_cnt #(
    .MAX_LGR (MAX_LGR),
    .MIN_LGR (MIN_LGR),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .cnt     (cnt),
    .at_max  (at_max),
    .too_few (too_few),
    .held    (cnt_held)
  );

  ctl_hunt_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (abort_i),
    .rx_valid     (rx_valid_i),
    .cls          (cls),
    .pad_ok       (pad_ok),
    .at_max       (at_max),
    .too_few      (too_few),
    .cnt_held     (cnt_held),
    .mon_end_i    (mon_end_i),
    .state        (state),
    .ev_store     (ev_store),
    .ev_restart   (ev_restart),
    .ev_flush     (ev_flush),
    .ev_done      (ev_done),
    .ev_mon_enter (ev_mon_enter),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_byte_o  <= '0;
      cap_valid_o <= 1'b0;
      cap_flush_o <= 1'b0;
      done_o      <= 1'b0;
      lgr_count_o <= '0;
    end else begin
      cap_valid_o <= ev_store;
      cap_flush_o <= ev_flush;
      done_o      <= ev_done;
      if (ev_store) cap_byte_o <= rx_byte_i;
      if (abort_i)      lgr_count_o <= '0;
      else if (ev_done) lgr_count_o <= cnt;
    end
  end

  assign mon_req_o = (state == ST_MON);

endmodule

// File: rtl/ctl_seq_hunter_chk.sv
module ctl_seq_hunter_chk
  import ctl_hunt_pkg::*;
#(
  parameter int MAX_LGR = 15,
  parameter int MIN_LGR = 2,
  parameter int CNT_W   = $clog2(MAX_LGR + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort_i,
  input logic [7:0]       cap_byte_o,
  input logic             cap_valid_o,
  input logic             cap_flush_o,
  input logic             done_o,
  input logic [CNT_W-1:0] lgr_count_o,
  input logic             mon_req_o
);

  localparam logic [CNT_W:0]   MAX_W = (CNT_W+1)'(MAX_LGR);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LGR);

  logic           enq_pend;
  logic [CNT_W:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_pend <= 1'b0;
      gcnt     <= '0;
    end else begin
      if (abort_i || cap_flush_o || done_o) enq_pend <= 1'b0;
      else if (cap_valid_o && cap_byte_o == CH_ENQ) enq_pend <= 1'b1;
      if (abort_i || cap_flush_o || done_o) gcnt <= '0;
      else if (cap_valid_o && is_graphic(cap_byte_o)) gcnt <= gcnt + 1'b1;
    end
  end

  p_syn_never_captured_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |-> (cap_byte_o != CH_SYN));

  p_done_after_enq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> enq_pend);

  p_done_count_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lgr_count_o == '0 || lgr_count_o >= MIN_C));

  p_done_flush_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && cap_flush_o));

  p_capture_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt <= MAX_W);

  p_monitor_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_req_o |-> (!cap_valid_o && !done_o));

  p_abort_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_i) |-> (!mon_req_o && lgr_count_o == '0 && !done_o && !cap_valid_o));

endmodule

bind ctl_seq_hunter ctl_seq_hunter_chk #(
  .MAX_LGR (MAX_LGR),
  .MIN_LGR (MIN_LGR),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .cap_byte_o  (cap_byte_o),
  .cap_valid_o (cap_valid_o),
  .cap_flush_o (cap_flush_o),
  .done_o      (done_o),
  .lgr_count_o (lgr_count_o),
  .mon_req_o   (mon_req_o)
);

// File: tb/ctl_seq_hunter_test.sv
module ctl_seq_hunter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       rx_valid_i = 1'b0;
  logic       mon_end_i = 1'b0;
  logic [7:0] cap_byte_o;
  logic       cap_valid_o, cap_flush_o, done_o, mon_req_o;
  logic [3:0] lgr_count_o;

  always #5 clk = ~clk;

  ctl_seq_hunter uut (
    .clk (clk), .rst_n (rst_n), .abort_i (abort_i),
    .rx_byte_i (rx_byte_i), .rx_valid_i (rx_valid_i), .mon_end_i (mon_end_i),
    .cap_byte_o (cap_byte_o), .cap_valid_o (cap_valid_o), .cap_flush_o (cap_flush_o),
    .done_o (done_o), .lgr_count_o (lgr_count_o), .mon_req_o (mon_req_o)
  );

  localparam int K_CAP = 0, K_FLUSH = 1, K_DONE = 2;

  typedef struct {
    int         kind;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [7:0] val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    cur_tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_cap(input logic [7:0] b, input string tag);
    push(K_CAP, b, tag);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte_i  = b;
    rx_valid_i = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_valid_i = 1'b0;
    end
  endtask

  task automatic graphics(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_cap(8'hC1 + 8'(i % 9), tag);
      send(8'hC1 + 8'(i % 9));
    end
  endtask

  task automatic end_block;
    @(negedge clk);
    rx_valid_i = 1'b0;
    mon_end_i  = 1'b1;
    @(negedge clk);
    mon_end_i  = 1'b0;
  endtask

  task automatic do_abort;
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_byte_i  = 8'hC5;
    abort_i    = 1'b1;
    @(negedge clk);
    abort_i    = 1'b0;
    rx_valid_i = 1'b0;
  endtask

  // Scoreboard monitor: every output event must match the head of the queue
  task automatic compare(input int kind, input logic [7:0] val);
    exp_t e;
    n_cmp++;
    if (q.size() == 0) begin
      n_bad++;
      $display("FAIL %s: unexpected event kind %0d value %0h, expected none", cur_tag, kind, val);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.val != val) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d value %0h expected kind %0d value %0h",
                 e.tag, kind, val, e.kind, e.val);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cap_valid_o) compare(K_CAP, cap_byte_o);
        if (cap_flush_o) compare(K_FLUSH, 8'h00);
        if (done_o)      compare(K_DONE, {4'h0, lgr_count_o});
      end
    end
  end

  task automatic drain(input string tag);
    idle(3);
    chk(q.size() == 0, tag, q.size(), 0);
    q.delete();
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cap_valid_o && !cap_flush_o && !done_o, "R1 strobes", {cap_valid_o, cap_flush_o, done_o}, 0);
    chk(!mon_req_o, "R1 mon_req", mon_req_o, 0);
    chk(lgr_count_o == 0, "R1 count", lgr_count_o, 0);

    // R4 bare ENQ line bid
    exp_cap(8'h2D, "R4"); send(8'h2D);
    push(K_DONE, 8'd0, "R4"); send(8'hFF);
    drain("R4 bare bid");

    // R2 R3 three graphics with SYN bytes in between
    exp_cap(8'hC1, "R2"); send(8'hC1);
    send(8'h32);
    exp_cap(8'h40, "R2"); send(8'h40);
    send(8'h32); send(8'h32);
    exp_cap(8'hFE, "R2"); send(8'hFE);
    exp_cap(8'h2D, "R3"); send(8'h2D);
    push(K_DONE, 8'd3, "R3"); send(8'h7F);
    drain("R3 syn drop");
    // R12 count held after a later capture
    exp_cap(8'hC7, "R12"); send(8'hC7);
    idle(1);
    chk(lgr_count_o == 4'd3, "R12 hold", lgr_count_o, 3);
    push(K_FLUSH, 8'h00, "R12"); do_abort();
    drain("R12");

    // R4 upper boundary: 15 graphics
    graphics(15, "R4");
    exp_cap(8'h2D, "R4"); send(8'h2D);
    push(K_DONE, 8'd15, "R4"); send(8'hFF);
    drain("R4 fifteen");

    // R4 lower boundary: 2 graphics
    graphics(2, "R4");
    exp_cap(8'h2D, "R4"); send(8'h2D);
    push(K_DONE, 8'd2, "R4"); send(8'h0F);
    drain("R4 two");

    // R6 one graphic then ENQ
    graphics(1, "R6");
    push(K_FLUSH, 8'h00, "R6"); send(8'h2D);
    exp_cap(8'h2D, "R6"); send(8'h2D);
    push(K_DONE, 8'd0, "R6"); send(8'hFF);
    drain("R6");

    // R7 sixteen graphics overflow, then fresh count
    graphics(15, "R7");
    push(K_FLUSH, 8'h00, "R7"); send(8'hC9);
    graphics(2, "R7");
    exp_cap(8'h2D, "R7"); send(8'h2D);
    push(K_DONE, 8'd2, "R7"); send(8'hFF);
    drain("R7");

    // R5 bad pad after ENQ
    graphics(2, "R5");
    exp_cap(8'h2D, "R5"); send(8'h2D);
    push(K_FLUSH, 8'h00, "R5"); send(8'h3E);
    drain("R5");
    chk(lgr_count_o == 4'd2, "R5 no done count", lgr_count_o, 2);

    // R8 control byte restarts
    graphics(2, "R8");
    push(K_FLUSH, 8'h00, "R8"); send(8'h37);
    send(8'h37);
    send(8'hFF);
    exp_cap(8'h2D, "R8"); send(8'h2D);
    push(K_DONE, 8'd0, "R8"); send(8'hFF);
    drain("R8");

    // R9 STX hands the stream to the framer
    graphics(2, "R9");
    push(K_FLUSH, 8'h00, "R9"); send(8'h02);
    idle(1);
    chk(mon_req_o, "R9 stx raise", mon_req_o, 1);
    send(8'hC1); send(8'h2D); send(8'hFF);
    idle(1);
    chk(mon_req_o, "R9 hold", mon_req_o, 1);
    end_block();
    chk(!mon_req_o, "R9 release", mon_req_o, 0);
    exp_cap(8'h2D, "R9"); send(8'h2D);
    push(K_DONE, 8'd0, "R9"); send(8'hFF);
    drain("R9 stx");
    // R9 SOH and DLE STX
    send(8'h01); idle(1);
    chk(mon_req_o, "R9 soh", mon_req_o, 1);
    end_block();
    send(8'h10); send(8'h02); idle(1);
    chk(mon_req_o, "R9 dle stx", mon_req_o, 1);
    end_block();
    chk(!mon_req_o, "R9 dle release", mon_req_o, 0);
    drain("R9 soh");

    // R10 DLE then a non-STX byte
    graphics(2, "R10");
    send(8'h10);
    push(K_FLUSH, 8'h00, "R10"); send(8'hC4);
    exp_cap(8'h2D, "R10"); send(8'h2D);
    push(K_DONE, 8'd0, "R10"); send(8'hFF);
    drain("R10");

    // R11 abort with collected bytes after a nonzero done count
    graphics(3, "R11");
    exp_cap(8'h2D, "R11"); send(8'h2D);
    push(K_DONE, 8'd3, "R11"); send(8'hFF);
    graphics(2, "R11");
    push(K_FLUSH, 8'h00, "R11");
    do_abort();
    chk(lgr_count_o == 0, "R11 count", lgr_count_o, 0);
    chk(!mon_req_o, "R11 mon", mon_req_o, 0);
    drain("R11");
    // R11 abort during monitor
    send(8'h02); idle(1);
    do_abort();
    chk(!mon_req_o, "R11 mon abort", mon_req_o, 0);
    exp_cap(8'h2D, "R11"); send(8'h2D);
    push(K_DONE, 8'd0, "R11"); send(8'hFF);
    drain("R11 mon");

    finished = 1'b1;
    summary();
  end

endmodule